// File: doc/BRIEF.md
# Real-Time Selector Crossbar

This block is the bufferless switch that carries hard real-time flits through a five-port mesh router (one local port and four neighbour directions). Each output link is fed by its own multiplexer. The multiplexer's select value is held in a small route table, and software writes that table before an application starts. Real-time routes are computed offline so that no two flows ever need the same output link. For that reason the switch has no arbitration, no acknowledgment and no storage. A flit presented at an input leaves on every output whose route entry selects that input, in the same clock cycle, so its latency through the router is fixed.

Each table entry belongs to one output. It holds a 3-bit input select and an enable bit. An output is valid only when its entry is enabled, the select names an existing input, and that input's valid flag is high. The same valid signal is exported per output as a busy indication. The best-effort switch allocator uses it to hold back buffered traffic from a link that a real-time flit is occupying in that cycle. Several outputs may name the same input, and this delivers one flit to many links with no extra logic. Mapping two inputs onto one output cannot be expressed, because each output has only one select. Table writes act at the next clock edge. Software must write the table only while no real-time traffic is in flight.

Top module: `rt_sel_xbar`

## Requirements
- R1: While reset is held and after it is released, every table entry is disabled, so all `out_vld`, `rt_busy` and `out_flit` bits are zero until a write enables an entry.
- R2: A write (`cfg_we` high, `cfg_port` below 5) updates the entry of output `cfg_port` at the rising clock edge. Outputs follow the old entry up to that edge and the new entry from that edge onward.
- R3: For an enabled entry whose select s is 0 to 4, output o carries `in_flit[s*46 +: 46]` and `in_vld[s]` combinationally, in the same cycle, with no storage: a flit is present exactly in the cycles its input is valid.
- R4: An output whose entry has the enable bit clear never asserts `out_vld`, whatever its inputs do.
- R5: Several outputs may select the same input, and each of them then carries an identical copy of that input's flit and valid flag.
- R6: Whenever `out_vld[o]` is low, the flit field `out_flit[o*46 +: 46]` is all zeros.
- R7: `rt_busy[o]` is high in exactly the cycles in which `out_vld[o]` is high.
- R8: An enabled entry whose select is 5, 6 or 7 names no input, and its output stays idle (valid low, flit zero).
- R9: A write whose `cfg_port` is 5, 6 or 7 changes no entry, so every output keeps its previous behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; disables all entries |
| in_flit | input | 230 | Real-time flits of the five inputs, input i in bits [i*46 +: 46] |
| in_vld | input | 5 | Valid flag per input, bit i for input i |
| cfg_we | input | 1 | Route table write strobe |
| cfg_port | input | 3 | Output whose entry is written |
| cfg_sel | input | 3 | Input number stored as the select |
| cfg_en | input | 1 | Enable bit stored in the entry |
| out_flit | output | 230 | Flits of the five outputs, output o in bits [o*46 +: 46] |
| out_vld | output | 5 | Valid flag per output link |
| rt_busy | output | 5 | Per-output indication that a real-time flit holds the link this cycle |

## Verification
The hardest behaviour to reach from the ports is the moment a table write takes effect. That instant is only visible if traffic is flowing on both the old and the new route around the write edge. The stimulus therefore keeps changing valid flits on all five inputs while it reprograms entries one per cycle, including back-to-back writes to the same output, and it compares each output both in the cycle before and the cycle after each edge. Fan-out, disabled entries, out-of-range selects and writes aimed at non-existent outputs are each reached by dedicated write sequences followed by several cycles of dense traffic.

// File: rtl/rt_xbar_pkg.sv
// Shared constants for the real-time selector crossbar.
// Assumes a five-port router: local port plus four mesh neighbours.
package rt_xbar_pkg;
    localparam int RT_PORTS  = 5;
    localparam int RT_FLIT_W = 46;
endpackage

// File: rtl/rt_sel_table.sv
// Route table: one entry per output holding an input select and an enable.
// Assumes software writes only while no real-time traffic is in flight;
// writes to an index at or above NPORT are dropped.
module rt_sel_table #(
    parameter int NPORT = rt_xbar_pkg::RT_PORTS,
    parameter int SEL_W = $clog2(NPORT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_port,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic                        cfg_en,
    output logic [NPORT-1:0][SEL_W-1:0] route_sel,
    output logic [NPORT-1:0]            route_en
);
    for (genvar e = 0; e < NPORT; e++) begin : g_entry
        logic hit;
        assign hit = cfg_we && (int'(cfg_port) == e);

        // Hold or replace this output's entry; reset disables it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_sel[e] <= '0;
                route_en[e]  <= 1'b0;
            end else if (hit) begin
                route_sel[e] <= cfg_sel;
                route_en[e]  <= cfg_en;
            end
        end
    end
endmodule

// File: rtl/rt_out_mux.sv
// One output of the crossbar: an NPORT-to-1 multiplexer gated by the enable.
// Assumes the select is static during traffic. A select that names no input
// leaves the output idle. The flit field is forced to zero when not valid.
module rt_out_mux #(
    parameter int NPORT  = rt_xbar_pkg::RT_PORTS,
    parameter int FLIT_W = rt_xbar_pkg::RT_FLIT_W,
    parameter int SEL_W  = $clog2(NPORT)
) (
    input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
    input  logic [NPORT-1:0]             in_vld,
    input  logic [SEL_W-1:0]             sel,
    input  logic                         en,
    output logic [FLIT_W-1:0]            out_flit,
    output logic                         out_vld
);
    logic [FLIT_W-1:0] pick_flit;
    logic              pick_vld;

    // Choose the selected input, then blank the flit when nothing is valid.
    always_comb begin
        pick_flit = '0;
        pick_vld  = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (en && (int'(sel) == i)) begin
                pick_flit = in_flit[i];
                pick_vld  = in_vld[i];
            end
        end
        out_vld  = pick_vld;
        out_flit = pick_vld ? pick_flit : '0;
    end
endmodule

// File: rtl/rt_sel_xbar.sv
// Bufferless real-time switch: a route table plus one multiplexer per output.
// Assumes offline routing guarantees no two flows share an output link, so
// no arbitration is present. The busy flags tell the best-effort allocator
// which links are taken by a real-time flit in the current cycle.
module rt_sel_xbar #(
    parameter  int NPORT  = rt_xbar_pkg::RT_PORTS,
    parameter  int FLIT_W = rt_xbar_pkg::RT_FLIT_W,
    localparam int SEL_W  = $clog2(NPORT),
    localparam int BUS_W  = NPORT * FLIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] in_flit,
    input  logic [NPORT-1:0] in_vld,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_port,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_en,
    output logic [BUS_W-1:0] out_flit,
    output logic [NPORT-1:0] out_vld,
    output logic [NPORT-1:0] rt_busy
);
    logic [NPORT-1:0][FLIT_W-1:0] in_arr;
    logic [NPORT-1:0][SEL_W-1:0]  route_sel;
    logic [NPORT-1:0]             route_en;

    rt_sel_table #(.NPORT(NPORT), .SEL_W(SEL_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_sel   (cfg_sel),
        .cfg_en    (cfg_en),
        .route_sel (route_sel),
        .route_en  (route_en)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Split the flat input bus into per-input slices.
        assign in_arr[p] = in_flit[p*FLIT_W +: FLIT_W];

        rt_out_mux #(.NPORT(NPORT), .FLIT_W(FLIT_W), .SEL_W(SEL_W)) u_mux (
            .in_flit  (in_arr),
            .in_vld   (in_vld),
            .sel      (route_sel[p]),
            .en       (route_en[p]),
            .out_flit (out_flit[p*FLIT_W +: FLIT_W]),
            .out_vld  (out_vld[p])
        );
    end

    // The link is busy for best-effort traffic whenever a real-time flit leaves on it.
    assign rt_busy = out_vld;
endmodule

// File: rtl/rt_sel_xbar_chk.sv
// Checker for rt_sel_xbar, observing only its ports.
// Assumes a synchronous active-low reset.
module rt_sel_xbar_chk #(
    parameter  int NPORT  = rt_xbar_pkg::RT_PORTS,
    parameter  int FLIT_W = rt_xbar_pkg::RT_FLIT_W,
    localparam int SEL_W  = $clog2(NPORT),
    localparam int BUS_W  = NPORT * FLIT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] in_flit,
    input logic [NPORT-1:0] in_vld,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_port,
    input logic [SEL_W-1:0] cfg_sel,
    input logic             cfg_en,
    input logic [BUS_W-1:0] out_flit,
    input logic [NPORT-1:0] out_vld,
    input logic [NPORT-1:0] rt_busy
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_vld == '0));

    // R3
    vld_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld != '0) |-> (in_vld != '0));

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        // R6
        idle_flit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_vld[o] |-> (out_flit[o*FLIT_W +: FLIT_W] == '0));

        // R4
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_port) == o && !cfg_en) |=> !out_vld[o]);

        // R8
        bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_port) == o && int'(cfg_sel) >= NPORT) |=> !out_vld[o]);

        // R2
        write_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_port) == o && cfg_en && int'(cfg_sel) < NPORT)
            |=> (out_vld[o] == in_vld[$past(cfg_sel)]));
    end
endmodule

bind rt_sel_xbar rt_sel_xbar_chk #(.NPORT(NPORT), .FLIT_W(FLIT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_flit  (in_flit),
    .in_vld   (in_vld),
    .cfg_we   (cfg_we),
    .cfg_port (cfg_port),
    .cfg_sel  (cfg_sel),
    .cfg_en   (cfg_en),
    .out_flit (out_flit),
    .out_vld  (out_vld),
    .rt_busy  (rt_busy)
);

// File: tb/test_rt_sel_xbar.sv
// Bench for rt_sel_xbar: a behavioural route model checked at every falling edge.
module test_rt_sel_xbar;
    localparam int NP = 5;
    localparam int FW = 46;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP*FW-1:0]  in_flit;
    logic [NP-1:0]     in_vld;
    logic              cfg_we;
    logic [2:0]        cfg_port, cfg_sel;
    logic              cfg_en;
    logic [NP*FW-1:0]  out_flit;
    logic [NP-1:0]     out_vld, rt_busy;

    int  errors = 0;
    int  checks = 0;
    int  m_sel [NP];
    bit  m_en  [NP];
    bit  live  = 1'b0;
    bit  done  = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    rt_sel_xbar i_rt_sel_xbar (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_vld(in_vld),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
        .out_flit(out_flit), .out_vld(out_vld), .rt_busy(rt_busy)
    );

    // Reference route table, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin m_sel[i] = 0; m_en[i] = 0; end
            live = 1'b1;
        end else if (cfg_we && cfg_port < NP) begin
            m_sel[cfg_port] = int'(cfg_sel);
            m_en[cfg_port]  = cfg_en;
        end
    end

    function automatic logic [FW-1:0] rnd_flit();
        logic [63:0] r;
        r = {$urandom, $urandom};
        return r[FW-1:0];
    endfunction

    task automatic compare();
        for (int o = 0; o < NP; o++) begin
            logic          ev;
            logic [FW-1:0] ef;
            string         tag;
            ev = 1'b0; ef = '0;
            if (!m_en[o])          tag = "R4";
            else if (m_sel[o] >= NP) tag = "R8";
            else begin
                tag = "R3";
                ev  = in_vld[m_sel[o]];
                ef  = ev ? in_flit[m_sel[o]*FW +: FW] : '0;
            end
            checks++;
            if (out_vld[o] !== ev) begin
                errors++;
                $display("FAIL %s/%s out%0d vld actual=%b expected=%b", phase, tag, o, out_vld[o], ev);
            end
            checks++;
            if (out_flit[o*FW +: FW] !== ef) begin
                errors++;
                $display("FAIL %s/%s out%0d flit actual=%h expected=%h", phase,
                         ev ? tag : "R6", o, out_flit[o*FW +: FW], ef);
            end
            checks++;
            if (rt_busy[o] !== ev) begin
                errors++;
                $display("FAIL %s/R7 out%0d busy actual=%b expected=%b", phase, o, rt_busy[o], ev);
            end
        end
    endtask

    // Advance one clock and compare all outputs at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (live) compare();
    endtask

    task automatic traffic(input int n, input int density);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < NP; i++) begin
                in_flit[i*FW +: FW] = rnd_flit();
                in_vld[i] = ($urandom % 100) < density;
            end
            step();
        end
    endtask

    task automatic wr(input int port, input int sel, input bit en);
        cfg_we = 1'b1; cfg_port = 3'(port); cfg_sel = 3'(sel); cfg_en = en;
        for (int i = 0; i < NP; i++) begin
            in_flit[i*FW +: FW] = rnd_flit();
            in_vld[i] = $urandom % 2;
        end
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_port = '0; cfg_sel = '0; cfg_en = 1'b0;
        in_vld = '1;
        for (int i = 0; i < NP; i++) in_flit[i*FW +: FW] = rnd_flit();
        // R1: outputs idle during reset and after release with inputs valid.
        phase = "R1";
        step(); step();
        rst_n = 1'b1;
        traffic(4, 100);
        // R2: program a rotating map one entry per cycle under live traffic.
        phase = "R2";
        for (int o = 0; o < NP; o++) wr(o, (o + 1) % NP, 1'b1);
        wr(2, 4, 1'b1); wr(2, 0, 1'b1);
        // R3: dense and varied traffic on a fixed map.
        phase = "R3";
        traffic(30, 70);
        // R5: all outputs fan out one input.
        phase = "R5";
        for (int o = 0; o < NP; o++) wr(o, 2, 1'b1);
        traffic(20, 60);
        // R4: disable two outputs.
        phase = "R4";
        wr(1, 2, 1'b0); wr(3, 0, 1'b0);
        traffic(15, 100);
        // R8: out-of-range selects with enable set.
        phase = "R8";
        wr(0, 5, 1'b1); wr(2, 6, 1'b1); wr(4, 7, 1'b1);
        traffic(15, 100);
        // R9: writes aimed at non-existent outputs.
        phase = "R9";
        wr(1, 3, 1'b1); wr(3, 4, 1'b1);
        wr(5, 0, 1'b0); wr(6, 1, 1'b0); wr(7, 2, 1'b0);
        traffic(15, 100);
        // R6: sparse traffic leaves many idle outputs.
        phase = "R6";
        for (int o = 0; o < NP; o++) wr(o, NP - 1 - o, 1'b1);
        traffic(30, 20);
        // Mixed writes and traffic.
        phase = "R2";
        for (int k = 0; k < 40; k++) begin
            wr($urandom % 8, $urandom % 8, $urandom % 2);
            traffic(2, 50);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule